// File: doc/BRIEF.md
# Palette Data Port with Component Sequencer

This block gives a host processor byte-wide access to the colour palette of a video display processor. The palette holds 64 entries, each with a red, a green and a blue component. The host selects an entry and a starting component through a palette control register, then moves data through a single data port. Each data-port access touches one component of the selected entry and then moves to the next component. After the last component, the sequence moves on to the next entry. A separate mode register can stop this stepping, with one bit for writes and one bit for reads.

The component position is a four-state machine: RED, GREEN, BLUE and VOID. Five transitions are defined.
- ADVANCE: RED to GREEN, or GREEN to BLUE, on a stepping access.
- WRAP: BLUE or VOID to RED on a stepping access. The palette index increments at the same time and wraps from 63 to 0.
- LOAD: a control-register write sets both the state and the index.
- HOLD: the state stays where it is on an inhibited access or when the data port is idle.
- RESET: an asynchronous reset forces RED with index 0.

VOID is a dummy slot. A data-port write while in VOID stores nothing, and a data-port read while in VOID returns zero.

Components keep only their implemented bits. Red keeps five colour bits plus a colour-key flag in bit 7. Green and blue keep five colour bits. Video readout of the palette is not part of this block.

Top module: `palport`

## Requirements
- R1: Asynchronous reset (rst_n low) clears the palette index, the component state (to RED), both inhibit bits, every stored component and rd_data to 0.
- R2: A write to the palette control register (reg_sel=1) loads the palette index from wr_data[7:2] and the component state from wr_data[1:0], with 0=RED, 1=GREEN, 2=BLUE and 3=VOID. A read of reg_sel=1 returns {index, state}.
- R3: A data-port write (reg_sel=0) stores wr_data AND 0x9F into red and wr_data AND 0x1F into green or blue. Writing 0xFF to red, green and blue in turn reads back as 0x9F, 0x1F and 0x1F.
- R4: In state VOID, a data-port write changes no stored component and a data-port read returns 0.
- R5: A stepping data-port access in RED moves to GREEN, and in GREEN moves to BLUE. In both cases the index does not change.
- R6: A stepping data-port access in BLUE or VOID moves to RED and increments the index, with index 63 wrapping to 0.
- R7: Mode register (reg_sel=2): bit 0 set stops stepping on data-port writes, and bit 1 set stops stepping on data-port reads. The write itself is still performed. A read of reg_sel=2 returns {6'b0, bit1, bit0}.
- R8: reg_sel=3 is reserved. A write there changes no state, and a read returns 0.
- R9: rd_data is registered and changes only on the clock edge of a read (rd_en high, wr_en low). When rd_en and wr_en are both high, only the write is performed, and rd_data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | 0 data port, 1 palette control, 2 mode, 3 reserved |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data byte |

## Verification
The bench builds the block with its default parameters: a 6-bit index, which gives 64 entries, and 8-bit data. With these values, a single control write is enough to place the index at 63, so the wrap to entry 0 is reached in a few accesses rather than after hundreds of steps. Random traffic of about three thousand bus operations mixes all four register selects, occasional inhibit settings and simultaneous read and write strobes. Directed steps pin down the mask readback, the VOID slot and the wrap from 63 to 0.

// File: rtl/palport_pkg.sv
package palport_pkg;

    typedef enum logic [1:0] {
        CMP_RED   = 2'd0,
        CMP_GREEN = 2'd1,
        CMP_BLUE  = 2'd2,
        CMP_VOID  = 2'd3
    } comp_e;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_MODE = 2'd2;
    localparam logic [1:0] SEL_RSV  = 2'd3;

    localparam int NUM_COMP = 3;

endpackage

// File: rtl/palport_seq.sv
module palport_seq
    import palport_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              mode_wr,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [DATA_W-1:0] wr_data,
    output logic [IDX_W-1:0]  idx_o,
    output comp_e             comp_o,
    output logic              winh_o,
    output logic              rinh_o,
    output logic              store_we
);

    comp_e             comp_q, comp_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic              winh_q, rinh_q;
    logic              step_s;
    logic              wrap_s;

    assign step_s = (data_wr && !winh_q) || (data_rd && !rinh_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comp_q <= CMP_RED;
            idx_q  <= '0;
        end else begin
            comp_q <= comp_d;
            idx_q  <= idx_d;
        end
    end

    // next state
    always_comb begin
        comp_d = comp_q;
        wrap_s = 1'b0;
        if (ctrl_wr) begin
            comp_d = comp_e'(wr_data[1:0]);
        end else if (step_s) begin
            unique case (comp_q)
                CMP_RED:   comp_d = CMP_GREEN;
                CMP_GREEN: comp_d = CMP_BLUE;
                CMP_BLUE: begin
                    comp_d = CMP_RED;
                    wrap_s = 1'b1;
                end
                CMP_VOID: begin
                    comp_d = CMP_RED;
                    wrap_s = 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        if (ctrl_wr)
            idx_d = wr_data[IDX_W+1:2];
        else if (wrap_s)
            idx_d = idx_q + 1'b1;
        else
            idx_d = idx_q;
    end

    // inhibit bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            winh_q <= 1'b0;
            rinh_q <= 1'b0;
        end else if (mode_wr) begin
            winh_q <= wr_data[0];
            rinh_q <= wr_data[1];
        end
    end

    // outputs
    always_comb begin
        store_we = 1'b0;
        unique case (comp_q)
            CMP_RED, CMP_GREEN, CMP_BLUE: store_we = data_wr;
            CMP_VOID:                     store_we = 1'b0;
        endcase
        idx_o  = idx_q;
        comp_o = comp_q;
        winh_o = winh_q;
        rinh_o = rinh_q;
    end

endmodule

// File: rtl/palport_store.sv
module palport_store
    import palport_pkg::*;
#(
    parameter int                IDX_W    = 6,
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] RED_MASK = 8'h9F,
    parameter logic [DATA_W-1:0] GB_MASK  = 8'h1F
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  comp_e                             comp,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_COMP-1:0][DATA_W-1:0]   rcomp
);

    localparam int ENTRIES = 1 << IDX_W;

    genvar k;
    generate
        for (k = 0; k < NUM_COMP; k++) begin : g_comp
            localparam logic [DATA_W-1:0] MASK = (k == 0) ? RED_MASK : GB_MASK;
            logic [DATA_W-1:0] mem [ENTRIES];
            logic              hit;

            assign hit = we && (comp == comp_e'(k));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int e = 0; e < ENTRIES; e++)
                        mem[e] <= '0;
                end else if (hit) begin
                    mem[idx] <= wdata & MASK;
                end
            end

            assign rcomp[k] = mem[idx];
        end
    endgenerate

endmodule

// File: rtl/palport_rdmux.sv
module palport_rdmux
    import palport_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_s,
    input  logic [1:0]                      sel,
    input  comp_e                           comp,
    input  logic [IDX_W-1:0]                idx,
    input  logic                            winh,
    input  logic                            rinh,
    input  logic [NUM_COMP-1:0][DATA_W-1:0] rcomp,
    output logic [DATA_W-1:0]               rd_data
);

    logic [DATA_W-1:0] data_val;
    logic [DATA_W-1:0] src_val;
    logic [DATA_W-1:0] rd_q;

    always_comb begin
        data_val = '0;
        unique case (comp)
            CMP_RED:   data_val = rcomp[0];
            CMP_GREEN: data_val = rcomp[1];
            CMP_BLUE:  data_val = rcomp[2];
            CMP_VOID:  data_val = '0;
        endcase
    end

    always_comb begin
        src_val = '0;
        unique case (sel)
            SEL_DATA: src_val = data_val;
            SEL_CTRL: src_val = DATA_W'({idx, comp});
            SEL_MODE: src_val = DATA_W'({rinh, winh});
            SEL_RSV:  src_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_s)
            rd_q <= src_val;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/palport.sv
module palport
    import palport_pkg::*;
#(
    parameter int                IDX_W    = 6,
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] RED_MASK = 8'h9F,
    parameter logic [DATA_W-1:0] GB_MASK  = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic                            rd_s;
    logic                            data_wr, data_rd, ctrl_wr, mode_wr;
    logic [IDX_W-1:0]                idx_w;
    comp_e                           comp_w;
    logic                            winh_w, rinh_w, store_we;
    logic [NUM_COMP-1:0][DATA_W-1:0] rcomp_w;

    // bus decode: a write wins over a read in the same cycle
    assign rd_s    = rd_en && !wr_en;
    assign data_wr = wr_en && (reg_sel == SEL_DATA);
    assign data_rd = rd_s  && (reg_sel == SEL_DATA);
    assign ctrl_wr = wr_en && (reg_sel == SEL_CTRL);
    assign mode_wr = wr_en && (reg_sel == SEL_MODE);

    palport_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .mode_wr  (mode_wr),
        .data_wr  (data_wr),
        .data_rd  (data_rd),
        .wr_data  (wr_data),
        .idx_o    (idx_w),
        .comp_o   (comp_w),
        .winh_o   (winh_w),
        .rinh_o   (rinh_w),
        .store_we (store_we)
    );

    palport_store #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .RED_MASK(RED_MASK), .GB_MASK(GB_MASK)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .comp  (comp_w),
        .idx   (idx_w),
        .wdata (wr_data),
        .rcomp (rcomp_w)
    );

    palport_rdmux #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_s    (rd_s),
        .sel     (reg_sel),
        .comp    (comp_w),
        .idx     (idx_w),
        .winh    (winh_w),
        .rinh    (rinh_w),
        .rcomp   (rcomp_w),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/palport_chk.sv
module palport_chk
    import palport_pkg::*;
#(
    parameter int                IDX_W    = 6,
    parameter int                DATA_W   = 8,
    parameter logic [DATA_W-1:0] RED_MASK = 8'h9F
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [IDX_W-1:0]  idx_w,
    input logic [1:0]        comp_w,
    input logic              winh_w,
    input logic              rinh_w
);

    logic port_wr, port_rd, steps, holds;
    assign port_wr = wr_en && reg_sel == 2'd0;
    assign port_rd = rd_en && !wr_en && reg_sel == 2'd0;
    assign steps   = (port_wr && !winh_w) || (port_rd && !rinh_w);
    assign holds   = (port_wr && winh_w) || (port_rd && rinh_w);

    // R4
    void_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && comp_w == 2'd3) |=> rd_data == '0);

    // R5
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (steps && comp_w < 2'd2) |=> (comp_w == $past(comp_w) + 2'd1) && $stable(idx_w));

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (steps && comp_w >= 2'd2) |=> (comp_w == 2'd0) && (idx_w == $past(idx_w) + 1'b1));

    // R7
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        holds |=> $stable(comp_w) && $stable(idx_w));

    // R3
    red_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && comp_w == 2'd0) |=> (rd_data & ~RED_MASK) == '0);

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> $stable(rd_data));

endmodule

bind palport palport_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .RED_MASK(RED_MASK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .idx_w   (idx_w),
    .comp_w  (comp_w),
    .winh_w  (winh_w),
    .rinh_w  (rinh_w)
);

// File: tb/palport_test.sv
module palport_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;

    // reference model
    logic [7:0] m_pal [64][3];
    logic [5:0] m_idx;
    logic [1:0] m_cnt;
    logic       m_winh, m_rinh;
    logic [7:0] m_rd;

    always #10 clk = ~clk;   // 50 MHz

    palport uut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [7:0] comp_mask(input logic [1:0] c);
        return (c == 2'd0) ? 8'h9F : 8'h1F;
    endfunction

    function automatic logic [7:0] model_read(input logic [1:0] sel);
        case (sel)
            2'd0:    return (m_cnt == 2'd3) ? 8'h00 : m_pal[m_idx][m_cnt];
            2'd1:    return {m_idx, m_cnt};
            2'd2:    return {6'b0, m_rinh, m_winh};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step();
        if (m_cnt < 2'd2) m_cnt = m_cnt + 2'd1;
        else begin
            m_cnt = 2'd0;
            m_idx = m_idx + 6'd1;
        end
    endtask

    task automatic model_reset();
        for (int e = 0; e < 64; e++)
            for (int c = 0; c < 3; c++) m_pal[e][c] = 8'h00;
        m_idx = '0; m_cnt = '0; m_winh = 0; m_rinh = 0; m_rd = '0;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic op(input logic [1:0] sel, input bit w, input bit r,
                      input logic [7:0] d, input string tag);
        @(negedge clk);
        reg_sel = sel; wr_en = w; rd_en = r; wr_data = d;
        if (w) begin
            case (sel)
                2'd0: begin
                    if (m_cnt != 2'd3) m_pal[m_idx][m_cnt] = d & comp_mask(m_cnt);
                    if (!m_winh) model_step();
                end
                2'd1: begin m_idx = d[7:2]; m_cnt = d[1:0]; end
                2'd2: begin m_winh = d[0]; m_rinh = d[1]; end
                default: ;
            endcase
        end else if (r) begin
            m_rd = model_read(sel);
            if (sel == 2'd0 && !m_rinh) model_step();
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check(tag, rd_data, m_rd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check("R1 rd_data after reset", rd_data, 8'h00);
        rst_n = 1'b1;
        op(2'd1, 0, 1, 8'h00, "R1 ctrl after reset");
        check("R1 ctrl literal", rd_data, 8'h00);
        op(2'd2, 0, 1, 8'h00, "R1 mode after reset");
        op(2'd0, 0, 1, 8'h00, "R1 palette after reset");

        // R3 mask readback
        op(2'd1, 1, 0, 8'h00, "R2 load");
        op(2'd0, 1, 0, 8'hFF, "R3 write red");
        op(2'd0, 1, 0, 8'hFF, "R3 write green");
        op(2'd0, 1, 0, 8'hFF, "R3 write blue");
        op(2'd1, 0, 1, 8'h00, "R6 index after blue");
        check("R6 ctrl literal", rd_data, 8'h04);
        op(2'd1, 1, 0, 8'h00, "R2 reload");
        op(2'd0, 0, 1, 8'h00, "R3 red");
        check("R3 red literal", rd_data, 8'h9F);
        op(2'd0, 0, 1, 8'h00, "R3 green");
        check("R3 green literal", rd_data, 8'h1F);
        op(2'd0, 0, 1, 8'h00, "R3 blue");
        check("R3 blue literal", rd_data, 8'h1F);

        // R4 void slot
        op(2'd1, 1, 0, 8'h17, "R2 load idx5 void");
        op(2'd0, 1, 0, 8'hAA, "R4 void write");
        op(2'd1, 0, 1, 8'h00, "R6 after void");
        check("R6 void wrap literal", rd_data, 8'h18);
        for (int c = 0; c < 3; c++) begin
            op(2'd1, 1, 0, {6'd5, 2'(c)}, "R2 load");
            op(2'd0, 0, 1, 8'h00, "R4 entry untouched");
            check("R4 untouched literal", rd_data, 8'h00);
        end
        op(2'd1, 1, 0, 8'h17, "R2 load void");
        op(2'd0, 0, 1, 8'h00, "R4 void read");
        check("R4 void read literal", rd_data, 8'h00);

        // R5 advance
        op(2'd1, 1, 0, 8'h08, "R2 load idx2");
        op(2'd0, 1, 0, 8'h33, "R5 write");
        op(2'd1, 0, 1, 8'h00, "R5 ctrl");
        check("R5 literal", rd_data, 8'h09);

        // R6 wrap 63 -> 0
        op(2'd1, 1, 0, 8'hFE, "R2 load idx63 blue");
        op(2'd0, 1, 0, 8'h05, "R6 write");
        op(2'd1, 0, 1, 8'h00, "R6 wrap");
        check("R6 wrap literal", rd_data, 8'h00);

        // R7 inhibits
        op(2'd2, 1, 0, 8'h01, "R7 set write inhibit");
        op(2'd1, 1, 0, 8'h1C, "R2 load idx7");
        op(2'd0, 1, 0, 8'h11, "R7 write 1");
        op(2'd0, 1, 0, 8'h11, "R7 write 2");
        op(2'd1, 0, 1, 8'h00, "R7 no step on write");
        check("R7 literal", rd_data, 8'h1C);
        op(2'd0, 0, 1, 8'h00, "R7 write done");
        check("R7 data literal", rd_data, 8'h11);
        op(2'd2, 1, 0, 8'h02, "R7 set read inhibit");
        op(2'd0, 0, 1, 8'h00, "R7 read 1");
        op(2'd0, 0, 1, 8'h00, "R7 read 2");
        op(2'd1, 0, 1, 8'h00, "R7 no step on read");
        check("R7 read literal", rd_data, 8'h1D);
        op(2'd2, 0, 1, 8'h00, "R7 mode readback");
        check("R7 mode literal", rd_data, 8'h02);
        op(2'd2, 1, 0, 8'h00, "R7 clear");

        // R8 reserved
        op(2'd3, 1, 0, 8'hFF, "R8 reserved write");
        op(2'd3, 0, 1, 8'h00, "R8 reserved read");
        op(2'd1, 0, 1, 8'h00, "R8 ctrl unchanged");

        // R9 simultaneous strobes
        op(2'd1, 0, 1, 8'h00, "R9 prime");
        op(2'd0, 1, 1, 8'h3C, "R9 write wins");
        op(2'd1, 0, 1, 8'h00, "R9 ctrl after");

        // random traffic
        void'($urandom(32'h5A5A_1234));
        for (int n = 0; n < 3000; n++) begin
            logic [3:0]  pick;
            logic [7:0]  d;
            logic [1:0]  sel;
            bit          w, r;
            pick = 4'($urandom % 16);
            d    = 8'($urandom);
            r    = 1'b0;
            w    = 1'b0;
            if (pick < 6)       begin sel = 2'd0; w = 1; end
            else if (pick < 11) begin sel = 2'd0; r = 1; end
            else if (pick == 11) begin sel = 2'd1; w = 1; end
            else if (pick == 12) begin sel = 2'd1; r = 1; end
            else if (pick == 13) begin sel = 2'd2; w = 1; d = (($urandom % 4) == 0) ? d : 8'h00; end
            else if (pick == 14) begin sel = 2'($urandom); r = 1; end
            else                 begin sel = 2'($urandom); w = 1; r = 1; end
            if (sel == 2'd0 && r && !w)
                op(sel, w, r, d, (m_cnt == 2'd3) ? "R4 random void read" : "R3 random data read");
            else if (sel == 2'd1)
                op(sel, w, r, d, "R2 random ctrl");
            else if (w && r)
                op(sel, w, r, d, "R9 random both");
            else
                op(sel, w, r, d, "R5 random access");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule